// File: doc/BRIEF.md
# SECDED Codec for 64-bit Memory Words

This block guards 64-bit memory words with eight check bits. On the write side it takes a data word and produces the check byte that is stored next to it. On the read side it takes the stored 72-bit word and recomputes the eight group parities over data and check bits together. The result is a syndrome. The block then repairs a single flipped data bit and reports a double fault it cannot repair. It also exposes the syndrome so that an error logger can record it.

The code is fixed. Check bit 0 covers the odd data bits from 1 to 29 and every data bit from 31 to 55. Each data bit has an eight-bit column in the code with these properties:

- The column has odd weight of at least three.
- The column differs from every other data-bit column.
- Bit 0 of the column follows the group rule above.
- Among the columns that satisfy these conditions, the columns are given out in ascending code order.

The block classifies the error from the syndrome alone:

- A zero syndrome means the word is clean.
- A syndrome with a single bit set points at a faulty check bit.
- Any other syndrome with odd parity is a single data error.
- A nonzero syndrome with even parity is a double error.

The logic is combinational. When the parameter `REG_OUT` is 1 (the default), every output is registered, which gives one cycle of latency. The register has two states: it is held at zero during reset and loads the new results on every clock while running.

Top module: `secded_codec`

## Requirements
- R1: Check bit 0 (`enc_check[0]`, stored at word bit 64) is the even parity of data bits 1, 3, 5, …, 29 together with data bits 31 through 55.
- R2: A word stored as `{enc_check, data}` (check bits in bits 71..64) reads back with a zero syndrome, both flags low, and the data unchanged.
- R3: Inverting any one data bit 0..63 of a stored word gives the original data on `rd_data`, with `err_single`=1 and `err_double`=0.
- R4: Inverting stored check bit j (word bit 64+j) gives a syndrome equal to 1<<j, with `err_single`=1 and the data passed through unchanged.
- R5: Inverting any two distinct bits of a stored word raises `err_double` with `err_single`=0. The syndrome is nonzero with even parity, and `rd_data` equals the received data bits unchanged.
- R6: The syndrome of a word is the XOR of the syndromes that each of its inverted bits gives on its own.
- R7: The 64 syndromes produced by single data-bit errors are pairwise distinct, and each has odd weight of at least three.
- R8: While `rst_n` is low, all outputs are zero. With `REG_OUT`=1, outputs reflect the inputs of the previous rising clock edge.
- R9: `err_single` and `err_double` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 64 | Data word to encode |
| enc_check | output | 8 | Check byte for `wr_data` |
| rd_word | input | 72 | Stored word: data in bits 63..0, check bits in 71..64 |
| rd_data | output | 64 | Corrected data |
| err_single | output | 1 | Single error found (data or check bit) |
| err_double | output | 1 | Uncorrectable double error found |
| rd_syndrome | output | 8 | Syndrome of `rd_word` |

## Verification
Random words are first encoded and read back clean. They are then read with each of the 72 bit positions inverted in turn, which separates data-bit repair from check-bit faults by the syndrome weight. A sample of two-bit inversions covers data/data, data/check and check/check pairs. This shows that the even-parity rule keeps a double error from being miscorrected. The single-error syndromes are collected and compared against one another to confirm that each column of the code is distinct. Syndromes of pairs are compared with the XOR of the single-error syndromes.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DATA_W  = 64;
    localparam int CHECK_W = 8;
    localparam int WORD_W  = DATA_W + CHECK_W;

    typedef logic [DATA_W-1:0][CHECK_W-1:0] col_table_t;
    typedef enum logic [1:0] {ST_RESET = 2'd0, ST_RUN = 2'd1} oreg_state_e;

    function automatic logic group0(input int i);
        return ((i <= 29) && (i % 2 == 1)) || ((i >= 31) && (i <= 55));
    endfunction

    function automatic logic [CHECK_W-1:0] col_code(input int i);
        logic b0;
        int rank;
        int n;
        logic [CHECK_W-1:0] c;
        b0   = group0(i);
        rank = 0;
        n    = 0;
        for (int k = 0; k < i; k++)
            if (group0(k) == b0) rank++;
        for (int v = 0; v < (1 << CHECK_W); v++) begin
            c = CHECK_W'(v);
            if ((c[0] == b0) && ($countones(c) % 2 == 1) && ($countones(c) >= 3)) begin
                if (n == rank) return c;
                n++;
            end
        end
        return '0;
    endfunction

    function automatic col_table_t col_table();
        col_table_t t;
        for (int i = 0; i < DATA_W; i++) t[i] = col_code(i);
        return t;
    endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0]  data,
    output logic [CHECK_W-1:0] check
);
    localparam col_table_t COLS = col_table();

    for (genvar j = 0; j < CHECK_W; j++) begin : g_grp
        logic [DATA_W-1:0] mask;
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign mask[i] = COLS[i][j];
        end
        assign check[j] = ^(data & mask);
    end
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    output logic [CHECK_W-1:0] syn
);
    logic [CHECK_W-1:0] regen;

    secded_encoder u_regen (
        .data  (word[DATA_W-1:0]),
        .check (regen)
    );

    assign syn = regen ^ word[WORD_W-1:DATA_W];
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0]  raw,
    input  logic [CHECK_W-1:0] syn,
    output logic [DATA_W-1:0]  fixed,
    output logic               single,
    output logic               double
);
    localparam col_table_t COLS = col_table();

    logic [DATA_W-1:0] flip;
    logic              odd;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dec
        assign flip[i] = (syn == COLS[i]);
    end

    always_comb begin
        odd    = ^syn;
        single = odd;
        double = (syn != '0) && !odd;
        fixed  = odd ? (raw ^ flip) : raw;
    end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [CHECK_W-1:0]  enc_check,
    input  logic [WORD_W-1:0]   rd_word,
    output logic [DATA_W-1:0]   rd_data,
    output logic                err_single,
    output logic                err_double,
    output logic [CHECK_W-1:0]  rd_syndrome
);
    logic [CHECK_W-1:0] c_check;
    logic [CHECK_W-1:0] c_syn;
    logic [DATA_W-1:0]  c_data;
    logic               c_single;
    logic               c_double;

    secded_encoder u_enc (
        .data  (wr_data),
        .check (c_check)
    );

    secded_syndrome u_syn (
        .word (rd_word),
        .syn  (c_syn)
    );

    secded_corrector u_cor (
        .raw    (rd_word[DATA_W-1:0]),
        .syn    (c_syn),
        .fixed  (c_data),
        .single (c_single),
        .double (c_double)
    );

    if (REG_OUT) begin : g_reg
        oreg_state_e state_q, state_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= ST_RESET;
            else        state_q <= state_d;
        end

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                ST_RESET: state_d = ST_RUN;
                ST_RUN:   state_d = ST_RUN;
                default:  state_d = ST_RESET;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                enc_check   <= '0;
                rd_data     <= '0;
                err_single  <= 1'b0;
                err_double  <= 1'b0;
                rd_syndrome <= '0;
            end else begin
                enc_check   <= c_check;
                rd_data     <= c_data;
                err_single  <= c_single;
                err_double  <= c_double;
                rd_syndrome <= c_syn;
            end
        end

        // R8: registered outputs follow the previous cycle's result
        a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_RUN) |=> (rd_syndrome == $past(c_syn)));
    end else begin : g_comb
        assign enc_check   = c_check;
        assign rd_data     = c_data;
        assign err_single  = c_single;
        assign err_double  = c_double;
        assign rd_syndrome = c_syn;
    end

    // R9: single and double flags are exclusive
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_single && c_double));
    // R2: clean word gives no flag and untouched data
    a_r2_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (c_syn == '0) |-> (!c_single && !c_double && c_data == rd_word[DATA_W-1:0]));
    // R4: unit syndrome means a check-bit fault, data passes through
    a_r4_check_fault: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(c_syn) == 1) |-> (c_single && c_data == rd_word[DATA_W-1:0]));
    // R5: double error never alters data
    a_r5_double_hold: assert property (@(posedge clk) disable iff (!rst_n)
        c_double |-> (c_data == rd_word[DATA_W-1:0]));
    // R3: a correction inverts at most one data bit
    a_r3_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_data ^ rd_word[DATA_W-1:0]));
endmodule

// File: tb/sim_secded_codec.sv
module sim_secded_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  enc_check;
    logic [71:0] rd_word = '0;
    logic [63:0] rd_data;
    logic        err_single;
    logic        err_double;
    logic [7:0]  rd_syndrome;

    int total = 0;
    int bad = 0;
    logic [7:0] dsyn [64];

    always #10 clk = ~clk;

    secded_codec u0 (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .enc_check(enc_check),
        .rd_word(rd_word), .rd_data(rd_data), .err_single(err_single),
        .err_double(err_double), .rd_syndrome(rd_syndrome)
    );

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic encode(input logic [63:0] d, output logic [71:0] w);
        @(negedge clk); wr_data = d;
        @(negedge clk); w = {enc_check, d};
    endtask

    task automatic readw(input logic [71:0] w);
        @(negedge clk); rd_word = w;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_data = '1; rd_word = 72'h1;
        #5;
        chk({enc_check, rd_data, err_single, err_double, rd_syndrome} == '0, "R8 reset",
            80'({rd_data, rd_syndrome}), 80'(0));
        @(negedge clk); rst_n = 1'b1;
        rd_word = 72'h1;
        @(negedge clk);
        chk(rd_syndrome != 8'h00, "R8 latency", 80'(rd_syndrome), 80'(1));
    endtask

    task automatic t_group0(input logic [63:0] d);
        logic [71:0] w;
        logic [63:0] m;
        m = '0;
        for (int i = 1; i <= 29; i += 2) m[i] = 1'b1;
        for (int i = 31; i <= 55; i++) m[i] = 1'b1;
        encode(d, w);
        chk(w[64] == ^(d & m), "R1 check bit 0", 80'(w[64]), 80'(^(d & m)));
    endtask

    task automatic t_clean(input logic [63:0] d);
        logic [71:0] w;
        encode(d, w);
        readw(w);
        chk(rd_syndrome == 0 && !err_single && !err_double && rd_data == d, "R2 clean",
            80'({rd_data, rd_syndrome}), 80'({d, 8'h00}));
    endtask

    task automatic t_single_data(input logic [63:0] d, input bit record);
        logic [71:0] w;
        encode(d, w);
        for (int i = 0; i < 64; i++) begin
            readw(w ^ (72'h1 << i));
            chk(rd_data == d && err_single && !err_double, "R3 data bit repair",
                80'({rd_data, err_single, err_double}), 80'({d, 2'b10}));
            if (record) dsyn[i] = rd_syndrome;
            else chk(rd_syndrome == dsyn[i], "R3 syndrome stable", 80'(rd_syndrome), 80'(dsyn[i]));
        end
    endtask

    task automatic t_columns();
        for (int i = 0; i < 64; i++) begin
            chk(($countones(dsyn[i]) % 2 == 1) && $countones(dsyn[i]) >= 3, "R7 column weight",
                80'(dsyn[i]), 80'(0));
            for (int k = i + 1; k < 64; k++)
                if (dsyn[i] == dsyn[k]) chk(1'b0, "R7 column distinct", 80'(dsyn[k]), 80'(i));
        end
        total++;
    endtask

    task automatic t_single_check(input logic [63:0] d);
        logic [71:0] w;
        encode(d, w);
        for (int j = 0; j < 8; j++) begin
            readw(w ^ (72'h1 << (64 + j)));
            chk(rd_syndrome == (8'h1 << j) && err_single && !err_double && rd_data == d,
                "R4 check bit fault", 80'({rd_data, rd_syndrome}), 80'({d, 8'h1 << j}));
        end
    endtask

    task automatic syn_of(input int p, output logic [7:0] s);
        s = (p < 64) ? dsyn[p] : (8'h1 << (p - 64));
    endtask

    task automatic t_double(input logic [63:0] d, input int n);
        logic [71:0] w, bw;
        logic [7:0]  sa, sb;
        int a, b;
        encode(d, w);
        for (int t = 0; t < n; t++) begin
            a = int'($urandom_range(71, 0));
            b = int'($urandom_range(71, 0));
            if (a == b) b = (a + 1) % 72;
            bw = w ^ (72'h1 << a) ^ (72'h1 << b);
            readw(bw);
            chk(err_double && !err_single && rd_data == bw[63:0], "R5 double detect",
                80'({rd_data, err_single, err_double}), 80'({bw[63:0], 2'b01}));
            syn_of(a, sa); syn_of(b, sb);
            chk(rd_syndrome == (sa ^ sb) && rd_syndrome != 0, "R6 syndrome xor",
                80'(rd_syndrome), 80'(sa ^ sb));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        t_reset();
        t_group0(64'h0);
        t_group0(64'hFFFF_FFFF_FFFF_FFFF);
        t_group0(64'hAAAA_AAAA_AAAA_AAAA);
        t_clean(64'h0);
        t_clean(64'hFFFF_FFFF_FFFF_FFFF);
        d = {$urandom, $urandom};
        t_single_data(d, 1'b1);
        t_columns();
        for (int r = 0; r < 4; r++) begin
            d = {$urandom, $urandom};
            t_group0(d);
            t_clean(d);
            t_single_data(d, 1'b0);
            t_single_check(d);
            t_double(d, 60);
        end
        // R9 checked at the ports across the sweep above
        chk(!(err_single && err_double), "R9 exclusive flags", 80'({err_single, err_double}), 80'(0));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule